// File: doc/BRIEF.md
# Overlapping 11011 Serial Pattern Detector

This block watches a one-bit serial stream, one bit per clock, and raises its match output during the very cycle in which the last bit of the pattern 11011 is present on the input. The output is a Mealy output: it is formed from the current state and the live input bit, so it needs no extra cycle of latency. The parent samples the match flag together with the input bit at the same clock edge.

The state sits in three JK-style flip-flops. Their J and K inputs come from excitation equations that were reduced by hand for a state encoding chosen by parity: every state entered on a 0 has an even code, and every state entered on a 1 has an odd code. A second register next to the first is loaded from equivalent D-style next-state equations and serves only as a cross-check.

A parameter selects how the machine continues after a match. With overlap, the trailing 11 of a match counts as the first two bits of the next match. Without overlap, the search starts again from nothing. Codes that the encoding never uses fall back to the idle state on the next clock.

Top module: `seq11011_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the state returns to idle (code 000). `detect` is 0 in every cycle after such an edge, even with `din` = 1, and any partial progress made before the reset is lost.
- R2: `detect` is 1 in the cycle where `din` = 1 completes the pattern 11011 (state code 101 together with input 1). It is 0 in every other cycle.
- R3: With `OVERLAP` = 1, a match moves the machine to the "seen 11" state (code 011). The input stream 11011011011 gives the output stream 00001001001.
- R4: With `OVERLAP` = 0, a match moves the machine to idle (code 000). The same input stream gives 00001000001.
- R5: Extra 1s received while the machine has seen 11 keep it in that state. The stream 1111011 gives a match on its final bit only.
- R6: A 0 that breaks the pattern sends the machine to the state that keeps the longest still-valid prefix. After 110 or 1101 that state is idle. After 11 it is the "seen 110" state (code 100). The stream 1101011011 matches only on its tenth bit, and 110011011 matches only on its ninth bit.
- R7: For any stream, `detect` equals a reference built from the last five bits. With overlap, a match needs the last five bits to be 11011. Without overlap, those five bits must also all come after the previous match or reset.
- R8: The state register holds only the codes 000, 001, 011, 100 and 101. After an input of 0 the state code is even. The JK-driven register and the D-driven shadow register hold the same value in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data bit for this cycle |
| detect | output | 1 | High in the cycle whose input bit completes 11011 |

## Verification
The bench runs a detector with overlap and one without overlap, side by side, on the same stream. Every cycle it compares both against a reference built from a five-bit window.

The directed streams target specific faults:
- The three-match example stream. A design that returned to idle after a match would miss the second and third matches. One that did not clear its progress in the non-overlap variant would report extra matches.
- Long runs of 1s. A design whose "seen 11" state fell back on an extra 1 would miss the match that follows.
- Streams broken by 1100 and 11010. A design that kept stale prefix bits would fire too early.
- A reset in the middle of 1101. A design that kept partial progress would fire on the next 1.

A long random stream weighted toward 1s then reaches every transition many times, in both variants.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  localparam int STATE_W = 3;
  typedef logic [STATE_W-1:0] code_t;

  // Parity-clustered encoding: states reached on a 0 are even, on a 1 odd.
  localparam code_t ST_IDLE = 3'b000;  // nothing yet
  localparam code_t ST_ONE  = 3'b001;  // seen 1
  localparam code_t ST_TWO  = 3'b011;  // seen 11
  localparam code_t ST_ZERO = 3'b100;  // seen 110
  localparam code_t ST_LAST = 3'b101;  // seen 1101

  typedef struct packed {
    code_t j;
    code_t k;
  } jk_t;

  function automatic logic code_legal(input code_t q);
    return (q == ST_IDLE) || (q == ST_ONE) || (q == ST_TWO) ||
           (q == ST_ZERO) || (q == ST_LAST);
  endfunction

  // One JK element: hold, clear, set, toggle.
  function automatic logic jk_apply(input logic q, input logic j, input logic k);
    logic n;
    case ({j, k})
      2'b00:   n = q;
      2'b01:   n = 1'b0;
      2'b10:   n = 1'b1;
      default: n = ~q;
    endcase
    return n;
  endfunction

  // Excitation with overlap: a match lands in "seen 11".
  function automatic jk_t excite_overlap(input logic x, input code_t q);
    jk_t r;
    r.j[2] = ~x & q[1];
    r.k[2] = ~x | q[0];
    r.j[1] = x & q[0];
    r.k[1] = ~x;
    r.j[0] = x;
    r.k[0] = ~x;
    return r;
  endfunction

  // Excitation without overlap: a match lands in idle.
  function automatic jk_t excite_single(input logic x, input code_t q);
    jk_t r;
    r.j[2] = ~x & q[1];
    r.k[2] = ~x | q[0];
    r.j[1] = x & q[0] & ~q[2];
    r.k[1] = ~x;
    r.j[0] = x;
    r.k[0] = ~x | q[2];
    return r;
  endfunction

  // Unused codes: clear every element so the next state is idle.
  function automatic jk_t excite(input logic ovl, input logic x, input code_t q);
    jk_t r;
    if (!code_legal(q)) begin
      r.j = '0;
      r.k = '1;
    end else if (ovl) begin
      r = excite_overlap(x, q);
    end else begin
      r = excite_single(x, q);
    end
    return r;
  endfunction

  // D-style next state, written from the reduced sum-of-products forms.
  function automatic code_t d_next(input logic ovl, input logic x, input code_t q);
    code_t n;
    n[2] = (~x & q[1]) | (x & q[2] & ~q[0]);
    if (ovl) begin
      n[1] = x & q[0];
      n[0] = x;
    end else begin
      n[1] = x & q[0] & ~q[2];
      n[0] = x & ~(q[2] & q[0]);
    end
    if (!code_legal(q)) n = ST_IDLE;
    return n;
  endfunction

  // Mealy output; code 111 never occurs, so Y1 is left out.
  function automatic logic match_out(input logic x, input code_t q);
    return x & q[2] & q[0];
  endfunction

endpackage

// File: rtl/seqdet_jk_ff.sv
module seqdet_jk_ff
  import seqdet_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= jk_apply(q, j, k);
  end

endmodule

// File: rtl/seqdet_excite.sv
module seqdet_excite
  import seqdet_pkg::*;
#(
  parameter bit OVERLAP = 1'b1
) (
  input  logic  x,
  input  code_t q,
  output code_t j,
  output code_t k
);

  jk_t drive;

  always_comb drive = excite(OVERLAP, x, q);

  assign j = drive.j;
  assign k = drive.k;

endmodule

// File: rtl/seqdet_shadow.sv
module seqdet_shadow
  import seqdet_pkg::*;
#(
  parameter bit OVERLAP = 1'b1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  x,
  output code_t q
);

  always_ff @(posedge clk) begin
    if (rst) q <= ST_IDLE;
    else     q <= d_next(OVERLAP, x, q);
  end

endmodule

// File: rtl/seq11011_detector.sv
module seq11011_detector
  import seqdet_pkg::*;
#(
  parameter bit OVERLAP = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic detect
);

  code_t state_jk;   // the state that drives the output
  code_t state_d;    // D-equation shadow, read only by the checker
  code_t j_vec;
  code_t k_vec;

  seqdet_excite #(.OVERLAP(OVERLAP)) u_excite (
    .x (din),
    .q (state_jk),
    .j (j_vec),
    .k (k_vec)
  );

  for (genvar b = 0; b < STATE_W; b++) begin : g_elem
    seqdet_jk_ff u_ff (
      .clk (clk),
      .rst (rst),
      .j   (j_vec[b]),
      .k   (k_vec[b]),
      .q   (state_jk[b])
    );
  end

  seqdet_shadow #(.OVERLAP(OVERLAP)) u_shadow (
    .clk (clk),
    .rst (rst),
    .x   (din),
    .q   (state_d)
  );

  assign detect = match_out(din, state_jk);

endmodule

// File: rtl/seqdet_checker.sv
module seqdet_checker
  import seqdet_pkg::*;
#(
  parameter bit OVERLAP = 1'b1
) (
  input logic  clk,
  input logic  rst,
  input logic  din,
  input logic  detect,
  input code_t state_jk,
  input code_t state_d
);

  localparam code_t AFTER_MATCH = OVERLAP ? ST_TWO : ST_IDLE;

  // R1: the first cycle after reset is idle and quiet
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state_jk == ST_IDLE && !detect));

  // R2: a match needs the last state and a 1 on the input
  a_r2_detect_source: assert property (@(posedge clk) disable iff (rst)
    detect |-> (state_jk == ST_LAST && din));

  // R3 / R4: where the machine goes after a match
  a_r3_r4_after_match: assert property (@(posedge clk) disable iff (rst)
    detect |=> (state_jk == AFTER_MATCH));

  // R5: extra 1s hold "seen 11"
  a_r5_hold_two: assert property (@(posedge clk) disable iff (rst)
    (state_jk == ST_TWO && din) |=> (state_jk == ST_TWO));

  // R6: a 0 after "seen 11" goes to "seen 110"
  a_r6_two_zero: assert property (@(posedge clk) disable iff (rst)
    (state_jk == ST_TWO && !din) |=> (state_jk == ST_ZERO));

  // R8: parity clustering, legal codes, JK and D registers agree
  a_r8_even_after_zero: assert property (@(posedge clk) disable iff (rst)
    !din |=> !state_jk[0]);
  a_r8_legal_code: assert property (@(posedge clk) disable iff (rst)
    state_jk != 3'b010 && state_jk != 3'b110 && state_jk != 3'b111);
  a_r8_jk_equals_d: assert property (@(posedge clk) disable iff (rst)
    state_jk == state_d);

endmodule

bind seq11011_detector seqdet_checker #(.OVERLAP(OVERLAP)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .din      (din),
  .detect   (detect),
  .state_jk (state_jk),
  .state_d  (state_d)
);

// File: tb/test_seq11011_detector.sv
module test_seq11011_detector;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic det_ov;
  logic det_no;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference state: recent bits and how many are usable
  logic [4:0] hist_ov = '0;
  logic [4:0] hist_no = '0;
  int cnt_ov = 0;
  int cnt_no = 0;

  always #2 clk = ~clk;  // 4 ns period

  seq11011_detector #(.OVERLAP(1'b1)) i_seq11011_detector (
    .clk (clk), .rst (rst), .din (din), .detect (det_ov)
  );

  seq11011_detector #(.OVERLAP(1'b0)) i_seq11011_detector_single (
    .clk (clk), .rst (rst), .din (din), .detect (det_no)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    hist_ov = '0; hist_no = '0; cnt_ov = 0; cnt_no = 0;
  endtask

  // drive one bit, compare both detectors against the window model
  task automatic step(input logic b, input string tag, output logic o_ov, output logic o_no);
    logic [4:0] w_ov, w_no;
    logic e_ov, e_no;
    @(negedge clk);
    din = b;
    #1;
    w_ov = {hist_ov[3:0], b};
    w_no = {hist_no[3:0], b};
    e_ov = (w_ov == 5'b11011) && (cnt_ov >= 4);
    e_no = (w_no == 5'b11011) && (cnt_no >= 4);
    check({tag, " overlap"}, det_ov, e_ov);
    check({tag, " single"},  det_no, e_no);
    o_ov = det_ov;
    o_no = det_no;
    hist_ov = w_ov; cnt_ov++;
    if (e_no) begin hist_no = '0; cnt_no = 0; end
    else begin hist_no = w_no; cnt_no++; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    din = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check("R1 quiet in reset overlap", det_ov, 1'b0);
    check("R1 quiet in reset single",  det_no, 1'b0);
    din = 1'b0;
    rst = 1'b0;
    model_clear();
  endtask

  // literal stream check, MSB first
  task automatic run_vec(input logic [10:0] bits, input int n,
                         input logic [10:0] exp_ov, input logic [10:0] exp_no,
                         input string tag);
    logic [10:0] got_ov, got_no;
    logic a, c;
    got_ov = '0; got_no = '0;
    for (int i = n - 1; i >= 0; i--) begin
      step(bits[i], tag, a, c);
      got_ov[i] = a;
      got_no[i] = c;
    end
    checks++;
    if (got_ov !== exp_ov) begin
      errors++;
      $display("FAIL %s overlap stream: actual %b expected %b", tag, got_ov, exp_ov);
    end
    checks++;
    if (got_no !== exp_no) begin
      errors++;
      $display("FAIL %s single stream: actual %b expected %b", tag, got_no, exp_no);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a, c;
    do_reset();

    // R3 and R4: the example stream in both variants
    run_vec(11'b11011011011, 11, 11'b00001001001, 11'b00001000001, "R3 R4 example");
    do_reset();

    // R5: run of 1s holds "seen 11"
    run_vec(11'b00001111011, 11, 11'b00000000001, 11'b00000000001, "R5 ones run");
    do_reset();

    // R6: 11010 then a full pattern; 1100 then a full pattern
    run_vec(11'b01101011011, 11, 11'b00000000001, 11'b00000000001, "R6 break 11010");
    do_reset();
    run_vec(11'b00110011011, 11, 11'b00000000001, 11'b00000000001, "R6 break 1100");
    do_reset();

    // R1: reset in the middle of 1101 discards progress
    for (int i = 0; i < 4; i++) step((i != 2), "R1 prefix", a, c);
    do_reset();
    step(1'b1, "R1 after reset", a, c);
    check("R1 no match after reset overlap", a, 1'b0);
    check("R1 no match after reset single",  c, 1'b0);

    // R2: a match seen in the same cycle as the last bit
    do_reset();
    run_vec(11'b00000011011, 11, 11'b00000000001, 11'b00000000001, "R2 same cycle");

    // R7: random stream weighted toward 1s; R8 is watched by the checker meanwhile
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 4) != 0, "R7 random", a, c);
      if (i == 2000) do_reset();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule